// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Model

This block is a synthesizable model of a synchronous burst SRAM with a flow-through read path. The default word is 18 bits, made of two 9-bit byte lanes. Each lane carries eight data bits and one parity bit as a single unit. Address, chip selects, the two address strobes, the advance control, the write controls and write data are all captured on the rising clock edge. Read data for the captured address is presented combinationally from the array during the following cycle, with no output register. The depth is a parameter and defaults to 256 words.

A burst is started by one of two strobes. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write controls. After a burst has started, the advance input steps a 2-bit wrapping counter over the low address bits, in either linear or interleaved order. When advance is inactive the current address is held. Writes are qualified per lane, and a global write input can force both lanes to be written.

The bidirectional data pin is split into separate `din` and `dout` buses. `dout_en` tells whether the block is driving. While disabled, `dout` reads as zero. A sleep input freezes the block and keeps its contents. Entering and leaving sleep each take two clocks.

Top module: `fts_burst_sram`

## Requirements
- R1: A burst starts only if, on the clock edge that loads the strobe, `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A controller strobe seen with `cs2`=0 deselects the block, and `dout_en` is 0 in the next cycle.
- R2: A processor strobe (`pstrb_n`=0 with `cs1_n`=0) starts a read whatever the write inputs are, and writes nothing on that clock. If `cs1_n`=1, the processor strobe is ignored and the running burst holds its address.
- R3: When both strobes are low on the same edge, the processor strobe wins, so the cycle is a read.
- R4: A controller strobe (`cstrb_n`=0, `pstrb_n`=1) starts a write when the write indication is active, and a read otherwise. The write indication is active when `all_wr_n`=0, or when `byte_wr_n`=0 and at least one bit of `lane_sel_n` is 0.
- R5: `all_wr_n`=0 writes both lanes whatever `byte_wr_n` and `lane_sel_n` are. Lane 0 is `din[8:0]` and lane 1 is `din[17:9]`.
- R6: With `all_wr_n`=1 and `byte_wr_n`=0, each lane i whose `lane_sel_n[i]`=0 is written and the other lane is left unchanged. With `byte_wr_n`=1 and `all_wr_n`=1, nothing is written.
- R7: With `mode_ilv`=0, the low two address bits of the n-th word of a burst are (start + n) mod 4, and the upper bits stay fixed. A clock with `adv_n`=0 steps n. A clock with `adv_n`=1 and no strobe repeats the current address.
- R8: With `mode_ilv`=1, the low two address bits of the n-th word are start XOR n.
- R9: On any write cycle, including a single-lane write, `dout_en` is 0 whatever `oe_n` is. After a write, `dout_en` stays 0 through held cycles until a strobe or an advance occurs.
- R10: After reset, `dout_en` is 0. A read captured on an edge drives the stored word on `dout` in the cycle after that edge. Data written on one edge is returned by a read captured on the next edge. `dout` is zero whenever `dout_en` is 0.
- R11: On the first read cycle after a deselected state, the output drives whatever `oe_n` is. On later read cycles of the burst, `dout_en` requires `oe_n`=0.
- R12: `sleep` takes effect two edges after it rises and releases two edges after it falls. While asleep, strobes are ignored and `dout_en` is 0. Stored data survives sleep, and the block comes out of sleep deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| mode_ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| sleep | input | 1 | Sleep request, active high |
| addr | input | AW (8) | Word address |
| cs1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| pstrb_n | input | 1 | Processor address strobe, active low, read-only start |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, active low |
| byte_wr_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES (2) | Per-lane write select, active low |
| din | input | LANES*LANE_W (18) | Write data |
| oe_n | input | 1 | Output enable, active low, not registered |
| dout | output | LANES*LANE_W (18) | Read data, zero when not driven |
| dout_en | output | 1 | High when the block drives `dout` |

## Verification
The main stimulus is one long table-driven sequence:

- A global-write burst is followed by a processor-strobe read burst that wraps. This separates linear stepping from address holding.
- Single-lane writes are followed by controller-strobe reads. These show whether each lane's parity bit moves with its lane, and whether a byte-write with `byte_wr_n` high wrongly writes.
- The processor strobe is driven together with global write. This proves that such a clock is a read and not a write.
- A burst is written in interleaved order and read back with single linear-order reads. This separates the XOR sequence from the additive one.
- Directed sleep cycles count the entry and exit latency edge by edge.

// File: rtl/fts_pkg.sv
package fts_pkg;
   localparam int BURST_BITS = 2;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } fts_op_e;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_BEGIN = 2'd1,
      CYC_NEXT  = 2'd2,
      CYC_HOLD  = 2'd3
   } fts_cyc_e;
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq #(
   parameter int BB    = 2,
   parameter int ORDER = 0   // 0: pin selects, 1: linear only, 2: interleaved only
) (
   input  logic [BB-1:0] start,
   input  logic [BB-1:0] step,
   input  logic          ilv,
   output logic [BB-1:0] ofs
);
   logic [BB-1:0] lin_ofs;
   logic [BB-1:0] xor_ofs;

   assign lin_ofs = start + step;
   assign xor_ofs = start ^ step;

   generate
      if (ORDER == 1) begin : g_lin
         logic unused_ilv;
         assign unused_ilv = ilv;
         assign ofs = lin_ofs;
      end else if (ORDER == 2) begin : g_xor
         logic unused_ilv;
         assign unused_ilv = ilv;
         assign ofs = xor_ofs;
      end else begin : g_pin
         assign ofs = ilv ? xor_ofs : lin_ofs;
      end
   endgenerate
endmodule

// File: rtl/fts_wr_qual.sv
module fts_wr_qual #(
   parameter int LANES = 2
) (
   input  logic             all_wr_n,
   input  logic             byte_wr_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] lane_we,
   output logic             wr_req
);
   genvar i;
   generate
      for (i = 0; i < LANES; i++) begin : g_lane
         assign lane_we[i] = !all_wr_n || (!byte_wr_n && !lane_sel_n[i]);
      end
   endgenerate

   assign wr_req = |lane_we;
endmodule

// File: rtl/fts_cycle_dec.sv
module fts_cycle_dec
   import fts_pkg::*;
(
   input  logic     asleep,
   input  logic     act_q,
   input  logic     cs1_n,
   input  logic     cs2,
   input  logic     cs3_n,
   input  logic     pstrb_n,
   input  logic     cstrb_n,
   input  logic     adv_n,
   input  logic     wr_req,
   output fts_cyc_e cyc,
   output fts_op_e  op
);
   logic sel_ok;
   logic p_go;
   fts_op_e wr_or_rd;

   assign sel_ok   = !cs1_n && cs2 && !cs3_n;
   assign p_go     = !pstrb_n && !cs1_n;
   assign wr_or_rd = wr_req ? OP_WR : OP_RD;

   always_comb begin
      cyc = CYC_IDLE;
      op  = OP_NONE;
      if (asleep) begin
         cyc = CYC_IDLE;
         op  = OP_NONE;
      end else if (p_go) begin
         if (sel_ok) begin
            cyc = CYC_BEGIN;
            op  = OP_RD;
         end
      end else if (!cstrb_n) begin
         if (sel_ok) begin
            cyc = CYC_BEGIN;
            op  = wr_or_rd;
         end
      end else if (act_q) begin
         cyc = adv_n ? CYC_HOLD : CYC_NEXT;
         op  = wr_or_rd;
      end
   end
endmodule

// File: rtl/fts_array.sv
module fts_array #(
   parameter int DEPTH  = 256,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int W     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic [LANES-1:0] we,
   input  logic [AW-1:0]    waddr,
   input  logic [W-1:0]     wdata,
   input  logic [AW-1:0]    raddr,
   output logic [W-1:0]     rdata
);
   genvar i;
   generate
      for (i = 0; i < LANES; i++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (we[i]) begin
               mem[waddr] <= wdata[i*LANE_W +: LANE_W];
            end
         end

         assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
   import fts_pkg::*;
#(
   parameter int DEPTH      = 256,
   parameter int LANE_W     = 9,
   parameter int LANES      = 2,
   parameter int SLP_STAGES = 2,
   parameter int ORDER      = 0,
   localparam int AW        = $clog2(DEPTH),
   localparam int W         = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_ilv,
   input  logic             sleep,
   input  logic [AW-1:0]    addr,
   input  logic             cs1_n,
   input  logic             cs2,
   input  logic             cs3_n,
   input  logic             pstrb_n,
   input  logic             cstrb_n,
   input  logic             adv_n,
   input  logic             all_wr_n,
   input  logic             byte_wr_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic [W-1:0]     din,
   input  logic             oe_n,
   output logic [W-1:0]     dout,
   output logic             dout_en
);
   localparam int BB = BURST_BITS;
   localparam int HW = AW - BB;

   generate
      if (DEPTH < (1 << BB) || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least one burst");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
         $error("LANES and LANE_W must be positive");
      end
      if (SLP_STAGES < 1) begin : g_bad_slp
         $error("SLP_STAGES must be positive");
      end
      if (ORDER < 0 || ORDER > 2) begin : g_bad_order
         $error("ORDER must be 0, 1 or 2");
      end
   endgenerate

   // control state
   logic                  act_q;
   fts_op_e               op_q;
   logic [HW-1:0]         hi_q;
   logic [BB-1:0]         start_q;
   logic [BB-1:0]         cnt_q;
   logic                  first_q;
   logic                  hush_q;
   logic [SLP_STAGES-1:0] slp_sh;
   logic                  asleep;

   logic [LANES-1:0] lane_we;
   logic             wr_req;
   fts_cyc_e         cyc;
   fts_op_e          op_nx;
   logic [BB-1:0]    cnt_nx;
   logic [BB-1:0]    cur_ofs;
   logic [BB-1:0]    nxt_ofs;
   logic [AW-1:0]    tgt_addr;
   logic [AW-1:0]    rd_addr;
   logic [LANES-1:0] arr_we;
   logic [W-1:0]     arr_q;

   assign asleep = slp_sh[SLP_STAGES-1];
   assign cnt_nx = cnt_q + BB'(1);

   fts_wr_qual #(.LANES(LANES)) u_wq (
      .all_wr_n  (all_wr_n),
      .byte_wr_n (byte_wr_n),
      .lane_sel_n(lane_sel_n),
      .lane_we   (lane_we),
      .wr_req    (wr_req)
   );

   fts_cycle_dec u_dec (
      .asleep (asleep),
      .act_q  (act_q),
      .cs1_n  (cs1_n),
      .cs2    (cs2),
      .cs3_n  (cs3_n),
      .pstrb_n(pstrb_n),
      .cstrb_n(cstrb_n),
      .adv_n  (adv_n),
      .wr_req (wr_req),
      .cyc    (cyc),
      .op     (op_nx)
   );

   fts_burst_seq #(.BB(BB), .ORDER(ORDER)) u_seq_cur (
      .start(start_q),
      .step (cnt_q),
      .ilv  (mode_ilv),
      .ofs  (cur_ofs)
   );

   fts_burst_seq #(.BB(BB), .ORDER(ORDER)) u_seq_nxt (
      .start(start_q),
      .step (cnt_nx),
      .ilv  (mode_ilv),
      .ofs  (nxt_ofs)
   );

   assign rd_addr = {hi_q, cur_ofs};

   always_comb begin
      case (cyc)
         CYC_BEGIN: tgt_addr = addr;
         CYC_NEXT:  tgt_addr = {hi_q, nxt_ofs};
         default:   tgt_addr = rd_addr;
      endcase
   end

   assign arr_we = (op_nx == OP_WR) ? lane_we : '0;

   fts_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk  (clk),
      .we   (arr_we),
      .waddr(tgt_addr),
      .wdata(din),
      .raddr(rd_addr),
      .rdata(arr_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slp_sh <= '0;
      end else begin
         slp_sh[0] <= sleep;
         for (int i = 1; i < SLP_STAGES; i++) begin
            slp_sh[i] <= slp_sh[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         op_q    <= OP_NONE;
         hi_q    <= '0;
         start_q <= '0;
         cnt_q   <= '0;
         first_q <= 1'b0;
         hush_q  <= 1'b0;
      end else begin
         op_q   <= op_nx;
         hush_q <= (op_nx == OP_WR) || ((cyc == CYC_HOLD) && hush_q);
         case (cyc)
            CYC_BEGIN: begin
               act_q   <= 1'b1;
               hi_q    <= addr[AW-1:BB];
               start_q <= addr[BB-1:0];
               cnt_q   <= '0;
               first_q <= !act_q;
            end
            CYC_NEXT: begin
               cnt_q   <= cnt_nx;
               first_q <= 1'b0;
            end
            CYC_HOLD: begin
               first_q <= 1'b0;
            end
            default: begin
               act_q   <= 1'b0;
               first_q <= 1'b0;
            end
         endcase
      end
   end

   assign dout_en = (op_q == OP_RD) && !hush_q && !asleep && (!oe_n || first_q);
   assign dout    = dout_en ? arr_q : '0;
endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk
   import fts_pkg::*;
(
   input logic    clk,
   input logic    rst_n,
   input logic    cs1_n,
   input logic    cs2,
   input logic    cs3_n,
   input logic    pstrb_n,
   input logic    cstrb_n,
   input logic    adv_n,
   input logic    all_wr_n,
   input logic    oe_n,
   input logic    dout_en,
   input logic    asleep,
   input logic    act_q,
   input fts_op_e op_q
);
   // R1: controller strobe with cs2 low leaves the output undriven
   a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cstrb_n && !cs2) |-> !dout_en);

   // R2: processor strobe on a selected part reads, even with write inputs
   a_r2_pstrb_reads: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!pstrb_n && !cs1_n && cs2 && !cs3_n && !asleep) && !asleep && !oe_n)
      |-> dout_en);

   // R9: a controller-started global write keeps the output off
   a_r9_write_masks: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cstrb_n && pstrb_n && !cs1_n && cs2 && !cs3_n && !all_wr_n)
      |-> !dout_en);

   // R9: after a write, a held cycle without strobe or advance stays off
   a_r9_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_q == OP_WR && pstrb_n && cstrb_n && adv_n) |-> !dout_en);

   // R11: first read out of a deselected state drives regardless of oe_n
   a_r11_first_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!act_q && !pstrb_n && !cs1_n && cs2 && !cs3_n && !asleep) && !asleep)
      |-> dout_en);

   // R12: an edge taken while asleep accepts nothing
   a_r12_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      $past(asleep) |-> !dout_en);
endmodule

bind fts_burst_sram fts_burst_sram_chk chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs1_n   (cs1_n),
   .cs2     (cs2),
   .cs3_n   (cs3_n),
   .pstrb_n (pstrb_n),
   .cstrb_n (cstrb_n),
   .adv_n   (adv_n),
   .all_wr_n(all_wr_n),
   .oe_n    (oe_n),
   .dout_en (dout_en),
   .asleep  (asleep),
   .act_q   (act_q),
   .op_q    (op_q)
);

// File: tb/fts_burst_sram_tb_top.sv
module fts_burst_sram_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_ilv = 1'b0;
   logic        sleep = 1'b0;
   logic [7:0]  addr = '0;
   logic        cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
   logic        pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
   logic        all_wr_n = 1'b1, byte_wr_n = 1'b1;
   logic [1:0]  lane_sel_n = 2'b11;
   logic [17:0] din = '0;
   logic        oe_n = 1'b1;
   logic [17:0] dout;
   logic        dout_en;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   fts_burst_sram dut_i (
      .clk(clk), .rst_n(rst_n), .mode_ilv(mode_ilv), .sleep(sleep), .addr(addr),
      .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
      .adv_n(adv_n), .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n),
      .lane_sel_n(lane_sel_n), .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
   );

   typedef struct packed {
      logic        c1n;
      logic        c2;
      logic        psn;
      logic        ccn;
      logic        avn;
      logic        gwn;
      logic        bwn;
      logic [1:0]  sln;
      logic        oen;
      logic [7:0]  a;
      logic [17:0] d;
      logic        en;
      logic [17:0] q;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t TBL [NV] = '{
      // c1n c2  psn  ccn  avn  gwn  bwn  sln    oen  a      d          en   q          req
      '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,1'b1,8'h10,18'h3A5A5,1'b0,18'h00000,4'd4},  // R4/R5 write start
      '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,1'b1,8'h00,18'h01234,1'b0,18'h00000,4'd7},  // R7 -> 0x11
      '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,1'b1,8'h00,18'h2BEEF,1'b0,18'h00000,4'd7},  // R7 -> 0x12
      '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,1'b1,8'h00,18'h10F0F,1'b0,18'h00000,4'd7},  // R7 -> 0x13
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b0,18'h00000,4'd9},  // R9 hold after write
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,2'b11,1'b0,8'h12,18'h00000,1'b1,18'h2BEEF,4'd2},  // R2 read despite write
      '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,18'h10F0F,4'd7},  // R7 0x13
      '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,18'h3A5A5,4'd7},  // R7 wrap 0x10
      '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,18'h01234,4'd7},  // R7 0x11
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,18'h01234,4'd7},  // R7 hold
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,8'h00,18'h00000,1'b0,18'h00000,4'd11}, // R11 oe high later
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,2'b10,1'b0,8'h00,18'h3FFFF,1'b0,18'h00000,4'd9},  // R9 lane0 write off
      '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,8'h11,18'h00000,1'b1,18'h013FF,4'd6},  // R6 lane0 only
      '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,8'h10,18'h00000,1'b1,18'h3A5A5,4'd3},  // R3 pstrb wins
      '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,2'b01,1'b1,8'h10,18'h00000,1'b0,18'h00000,4'd6},  // R6 lane1 write
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,1'b0,8'h00,18'h3FFFF,1'b0,18'h00000,4'd9},  // R9 still hushed
      '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,8'h10,18'h00000,1'b1,18'h001A5,4'd6},  // R6 lane1 + no bw
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,8'h10,18'h00000,1'b0,18'h00000,4'd1},  // R1 cs2 low
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,8'h13,18'h00000,1'b1,18'h10F0F,4'd11}, // R11 first read
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,8'h00,18'h00000,1'b0,18'h00000,4'd11}, // R11 second needs oe
      '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,18'h10F0F,4'd2},  // R2 pstrb ignored
      '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,8'h10,18'h00000,1'b0,18'h00000,4'd1}   // R1 cs1 high
   };

   task automatic drive(input logic c1, input logic c2, input logic c3,
                        input logic ps, input logic cc, input logic av,
                        input logic gw, input logic bw, input logic [1:0] sl,
                        input logic oe, input logic [7:0] a, input logic [17:0] d);
      cs1_n = c1; cs2 = c2; cs3_n = c3; pstrb_n = ps; cstrb_n = cc; adv_n = av;
      all_wr_n = gw; byte_wr_n = bw; lane_sel_n = sl; oe_n = oe; addr = a; din = d;
      @(posedge clk);
      #2;
   endtask

   task automatic check(input logic en_e, input logic [17:0] q_e, input string tag);
      checks++;
      if (dout_en !== en_e || dout !== q_e) begin
         errors++;
         $display("FAIL %s: dout_en=%0b dout=%05h expected dout_en=%0b dout=%05h",
                  tag, dout_en, dout, en_e, q_e);
      end
   endtask

   // single controller-strobe read, selected, oe low
   task automatic rd_c(input logic [7:0] a, input logic [17:0] q_e, input string tag);
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, a, 18'h0);
      check(1'b1, q_e, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check(1'b0, 18'h0, "R10 reset state");
      rst_n = 1'b1;
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0);
      check(1'b0, 18'h0, "R10 idle after reset");

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].c1n, TBL[i].c2, 1'b0, TBL[i].psn, TBL[i].ccn, TBL[i].avn,
               TBL[i].gwn, TBL[i].bwn, TBL[i].sln, TBL[i].oen, TBL[i].a, TBL[i].d);
         check(TBL[i].en, TBL[i].q, $sformatf("R%0d row %0d", TBL[i].req, i));
      end

      // R1: cs3_n high on a controller strobe deselects
      drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h10, 18'h0);
      check(1'b0, 18'h0, "R1 cs3_n high");

      // R10: write then read on the very next edge
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 8'h40, 18'h15A5A);
      check(1'b0, 18'h0, "R9 global write start");
      rd_c(8'h40, 18'h15A5A, "R10 next-edge read");

      // R8: interleaved write burst from 0x22
      mode_ilv = 1'b1;
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 8'h22, 18'h11111);
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 8'h00, 18'h22222);
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 8'h00, 18'h33333);
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 8'h00, 18'h04444);
      check(1'b0, 18'h0, "R9 burst write off");
      mode_ilv = 1'b0;
      rd_c(8'h20, 18'h33333, "R8 word at 0x20");
      rd_c(8'h21, 18'h04444, "R8 word at 0x21");
      rd_c(8'h22, 18'h11111, "R8 word at 0x22");
      rd_c(8'h23, 18'h22222, "R8 word at 0x23");

      // R8: interleaved read burst from 0x21 -> 21,20,23,22
      mode_ilv = 1'b1;
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h21, 18'h0);
      check(1'b1, 18'h04444, "R8 ilv read n0");
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0);
      check(1'b1, 18'h33333, "R8 ilv read n1");
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0);
      check(1'b1, 18'h22222, "R8 ilv read n2");
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0);
      check(1'b1, 18'h11111, "R8 ilv read n3");
      mode_ilv = 1'b0;

      // deselect before sleep
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0);
      check(1'b0, 18'h0, "R1 deselect");

      // R12: sleep entry takes two edges
      sleep = 1'b1;
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h13, 18'h0);
      check(1'b1, 18'h10F0F, "R12 one edge into sleep still active");
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0);
      check(1'b0, 18'h0, "R12 asleep after two edges");
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 8'h13, 18'h3FFFF);
      check(1'b0, 18'h0, "R12 write ignored while asleep");
      sleep = 1'b0;
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0);
      check(1'b0, 18'h0, "R12 exit edge one");
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'h13, 18'h0);
      check(1'b0, 18'h0, "R12 exit edge two strobe dropped");
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 8'h13, 18'h0);
      check(1'b1, 18'h10F0F, "R12 contents kept after sleep");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule